// File: doc/BRIEF.md
# Interrupt Cause Aggregator

The block gathers interrupt events from three cause groups (transmit, receive and miscellaneous) and reduces them to a single interrupt line. Each group latches per-bit event pulses into a 32-bit cause register. A per-group mask decides which pending bits count towards that group's summary. A per-bit clear-mode word decides whether each cause bit is cleared by software writing a 1 to it or by software reading it.

A top-level summary register holds one sticky bit per group. It is cleared when it is read. A software enable word on top of the summary gates the interrupt output, so software can turn whole groups on or off without touching their masks. In the transmit group, bits 0 to 24 carry per-ring completions and a separate bit carries the general done event. In the receive group, a done bit and a buffer-near-full bit are independent. The block only latches these bits and attaches no meaning to them.

Software reaches every register through a single-cycle read/write port. A five-bit word address selects the group with its upper two bits and the register within the group with its lower three bits. Read data appears registered, in the cycle after the read strobe. The interrupt output comes from a two-state machine. State IRQ_IDLE moves to IRQ_ACTIVE when any enabled group has unmasked pending bits. IRQ_ACTIVE returns to IRQ_IDLE when none has.

Top module: `irq_cause_agg`

## Requirements
- R1: After reset every cause register and every clear-mode word is zero, every group mask reads all ones, the summary reads zero, the software enable word reads all ones and `irq` is low.
- R2: An event pulse sets its cause bit in the next cycle even while that bit is masked, and the raw readback (offset 5) shows it.
- R3: A write to mask-set (offset 1) sets every mask bit written as 1, and a write to mask-clear (offset 2) clears every mask bit written as 1. Bits written as 0 keep their value. The mask is read back at offset 4.
- R4: A write to the cause register (offset 0) clears each bit written as 1 whose clear-mode bit (offset 3) is 0. Bits written as 0, and bits whose clear-mode bit is 1, are unchanged.
- R5: A read of the cause register (offset 0) returns the cause value and clears exactly the returned bits whose clear-mode bit is 1. A read of the raw readback (offset 5) clears nothing.
- R6: When a cause bit receives an event in the same cycle as a write-1 clear or a read clear, the bit stays set.
- R7: Summary bit g (transmit 0, receive 1, miscellaneous 2, address group 3 offset 0) sets when group g has a pending unmasked cause bit. It stays set until the summary is read, and a read clears it unless the group is still pending in that cycle. The software enable word does not affect it.
- R8: `irq` rises one cycle after an enabled group first has an unmasked pending bit. It falls one cycle after the last such bit is cleared or masked.
- R9: The software enable word (group 3 offset 1) enables group g when its bit g is 0. With bits 0 to 2 all ones, `irq` stays low whatever is pending.
- R10: Address bits [4:3] select transmit (0), receive (1), miscellaneous (2) or top (3). Read data is valid the cycle after `rd_en`, and write-only offsets (1 and 2) read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address: group in [4:3], offset in [2:0] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tx_evt | input | 32 | Transmit event pulses, one per cause bit |
| rx_evt | input | 32 | Receive event pulses, one per cause bit |
| misc_evt | input | 32 | Miscellaneous event pulses, one per cause bit |
| irq | output | 1 | Interrupt output |

## Verification
Events are injected while masked, while unmasked, and in the same cycle as a write clear or a read clear. These cases separate latching from reporting and show which side wins a conflict. A clear-mode word with a mix of ones and zeros, hit with an all-ones write and then a read, shows that each bit follows its own mode rather than a global one. Pending and cleared patterns across several groups, under enable words that select one group, all groups or none, separate the sticky summary from the live interrupt output. The interrupt output is sampled in the cycle of each change and the cycle after, which confirms its one-cycle registered delay.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_GRP   = 3;
    localparam int GRP_SEL_W = 2;
    localparam int OFS_W     = 3;
    localparam int ADDR_W    = GRP_SEL_W + OFS_W;

    localparam logic [GRP_SEL_W-1:0] GRP_TOP = 2'd3;

    typedef enum logic [OFS_W-1:0] {
        OFS_CAUSE = 3'd0,
        OFS_MSET  = 3'd1,
        OFS_MCLR  = 3'd2,
        OFS_MODE  = 3'd3,
        OFS_MVAL  = 3'd4,
        OFS_RAW   = 3'd5
    } grp_ofs_e;

    typedef enum logic [OFS_W-1:0] {
        TOP_SUMMARY = 3'd0,
        TOP_ENABLE  = 3'd1
    } top_ofs_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic wr_cause;
        logic rd_cause;
        logic wr_mset;
        logic wr_mclr;
        logic wr_mode;
    } grp_acc_t;

endpackage

// File: rtl/cause_group.sv
module cause_group
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_i,
    input  grp_acc_t          acc_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cause_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] mode_o,
    output logic              pend_o
);

    logic [DATA_W-1:0] cause_q, cause_d;
    logic [DATA_W-1:0] mask_q, mask_d;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] clr_by_rd, clr_by_wr;

    // Clear sources: a read clears returned bits in read mode,
    // a write clears ones-written bits in write mode.
    always_comb begin
        clr_by_rd = acc_i.rd_cause ? (cause_q & mode_q) : '0;
        clr_by_wr = acc_i.wr_cause ? (wdata_i & ~mode_q) : '0;
        // event set is applied last so it wins any clear
        cause_d   = (cause_q & ~(clr_by_rd | clr_by_wr)) | evt_i;
    end

    always_comb begin
        mask_d = mask_q;
        if (acc_i.wr_mset) begin
            mask_d = mask_q | wdata_i;
        end else if (acc_i.wr_mclr) begin
            mask_d = mask_q & ~wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '1;
            mode_q  <= '0;
        end else begin
            cause_q <= cause_d;
            mask_q  <= mask_d;
            if (acc_i.wr_mode) begin
                mode_q <= wdata_i;
            end
        end
    end

    assign cause_o = cause_q;
    assign mask_o  = mask_q;
    assign mode_o  = mode_q;
    assign pend_o  = |(cause_q & ~mask_q);

    // R6: an event bit is present in the cause register the cycle after
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

    // R3: bits written to mask-set are masked afterwards
    a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i.wr_mset |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

    // R3: bits written to mask-clear are unmasked afterwards
    a_r3_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i.wr_mclr |=> ((mask_q & $past(wdata_i)) == '0));

    // R4/R5: a cause bit only falls after a cause write or cause read
    a_r4_clear_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cause_q) & ~cause_q) != '0) |->
            ($past(acc_i.wr_cause) || $past(acc_i.rd_cause)));

endmodule

// File: rtl/summary_reg.sv
module summary_reg
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] grp_pend_i,
    input  logic               rd_summary_i,
    input  logic               wr_enable_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [NUM_GRP-1:0] summary_o,
    output logic [DATA_W-1:0]  enable_o
);

    logic [NUM_GRP-1:0] summary_q;
    logic [DATA_W-1:0]  enable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            summary_q <= '0;
            enable_q  <= '1;
        end else begin
            // read clears returned bits; live pending re-sets them
            summary_q <= (rd_summary_i ? '0 : summary_q) | grp_pend_i;
            if (wr_enable_i) begin
                enable_q <= wdata_i;
            end
        end
    end

    assign summary_o = summary_q;
    assign enable_o  = enable_q;

    // R7: a summary bit only falls after a summary read
    a_r7_sticky_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(summary_q) & ~summary_q) != '0) |-> $past(rd_summary_i));

    // R7: a pending group is reflected in its summary bit next cycle
    a_r7_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_pend_i != '0) |=> ((summary_q & $past(grp_pend_i)) == $past(grp_pend_i)));

endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] grp_pend_i,
    input  logic [NUM_GRP-1:0] grp_off_i,
    output logic               irq_o
);

    irq_state_e state_q, state_d;
    logic       fire;

    assign fire = |(grp_pend_i & ~grp_off_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (fire)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!fire) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = (state_q == IRQ_ACTIVE);
    end

    // R9: all groups disabled keeps the output low
    a_r9_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_off_i == '1) |=> !irq_o);

    // R8: a rising output is preceded by an enabled pending group
    a_r8_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|(grp_pend_i & ~grp_off_i)));

endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [4:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] tx_evt,
    input  logic [DATA_W-1:0] rx_evt,
    input  logic [DATA_W-1:0] misc_evt,
    output logic              irq
);

    logic [GRP_SEL_W-1:0] grp_sel;
    logic [OFS_W-1:0]     ofs;

    logic [DATA_W-1:0]  evt_arr   [NUM_GRP];
    logic [DATA_W-1:0]  cause_arr [NUM_GRP];
    logic [DATA_W-1:0]  mask_arr  [NUM_GRP];
    logic [DATA_W-1:0]  mode_arr  [NUM_GRP];
    grp_acc_t           acc_arr   [NUM_GRP];
    logic [NUM_GRP-1:0] grp_pend;
    logic [NUM_GRP-1:0] summary;
    logic [DATA_W-1:0]  enable_w;
    logic               rd_summary, wr_enable;
    logic [DATA_W-1:0]  rd_mux, rdata_q;

    assign grp_sel = addr[ADDR_W-1 -: GRP_SEL_W];
    assign ofs     = addr[OFS_W-1:0];

    assign evt_arr[0] = tx_evt;
    assign evt_arr[1] = rx_evt;
    assign evt_arr[2] = misc_evt;

    always_comb begin
        for (int g = 0; g < NUM_GRP; g++) begin
            acc_arr[g].wr_cause = wr_en && (grp_sel == g[GRP_SEL_W-1:0]) && (ofs == OFS_CAUSE);
            acc_arr[g].rd_cause = rd_en && (grp_sel == g[GRP_SEL_W-1:0]) && (ofs == OFS_CAUSE);
            acc_arr[g].wr_mset  = wr_en && (grp_sel == g[GRP_SEL_W-1:0]) && (ofs == OFS_MSET);
            acc_arr[g].wr_mclr  = wr_en && (grp_sel == g[GRP_SEL_W-1:0]) && (ofs == OFS_MCLR);
            acc_arr[g].wr_mode  = wr_en && (grp_sel == g[GRP_SEL_W-1:0]) && (ofs == OFS_MODE);
        end
        rd_summary = rd_en && (grp_sel == GRP_TOP) && (ofs == TOP_SUMMARY);
        wr_enable  = wr_en && (grp_sel == GRP_TOP) && (ofs == TOP_ENABLE);
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        cause_group #(.DATA_W(DATA_W)) grp_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_arr[g]),
            .acc_i   (acc_arr[g]),
            .wdata_i (wdata),
            .cause_o (cause_arr[g]),
            .mask_o  (mask_arr[g]),
            .mode_o  (mode_arr[g]),
            .pend_o  (grp_pend[g])
        );
    end

    summary_reg #(.DATA_W(DATA_W)) summ_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .grp_pend_i   (grp_pend),
        .rd_summary_i (rd_summary),
        .wr_enable_i  (wr_enable),
        .wdata_i      (wdata),
        .summary_o    (summary),
        .enable_o     (enable_w)
    );

    irq_out_fsm irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_pend_i (grp_pend),
        .grp_off_i  (enable_w[NUM_GRP-1:0]),
        .irq_o      (irq)
    );

    always_comb begin
        rd_mux = '0;
        if (grp_sel == GRP_TOP) begin
            if (ofs == TOP_SUMMARY) begin
                rd_mux[NUM_GRP-1:0] = summary;
            end else if (ofs == TOP_ENABLE) begin
                rd_mux = enable_w;
            end
        end else begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (grp_sel == g[GRP_SEL_W-1:0]) begin
                    if (ofs == OFS_CAUSE || ofs == OFS_RAW) rd_mux = cause_arr[g];
                    else if (ofs == OFS_MODE)               rd_mux = mode_arr[g];
                    else if (ofs == OFS_MVAL)               rd_mux = mask_arr[g];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata = rdata_q;

    // R10: read data only changes after a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata_q));

endmodule

// File: tb/irq_cause_agg_tb_top.sv
module irq_cause_agg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] tx_evt = '0;
    logic [31:0] rx_evt = '0;
    logic [31:0] misc_evt = '0;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_cause_agg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tx_evt(tx_evt), .rx_evt(rx_evt),
        .misc_evt(misc_evt), .irq(irq)
    );

    function automatic logic [4:0] adr(input int g, input int o);
        return {g[1:0], o[2:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int g, input int o, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = adr(g, o); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int g, input int o, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = adr(g, o);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input int g, input logic [31:0] bits);
        @(negedge clk);
        case (g)
            0: tx_evt = bits;
            1: rx_evt = bits;
            default: misc_evt = bits;
        endcase
        @(negedge clk);
        tx_evt = '0; rx_evt = '0; misc_evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int g = 0; g < 3; g++) begin
            rd(g, 5, v); check("R1 cause", v, 32'h0);
            rd(g, 4, v); check("R1 mask", v, 32'hFFFF_FFFF);
            rd(g, 3, v); check("R1 mode", v, 32'h0);
        end
        rd(3, 0, v); check("R1 summary", v, 32'h0);
        rd(3, 1, v); check("R1 enable", v, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_latch_masked();
        logic [31:0] v;
        pulse(0, 32'h8100_0003);
        rd(0, 5, v); check("R2 masked latch", v, 32'h8100_0003);
        rd(0, 5, v); check("R5 raw no clear", v, 32'h8100_0003);
        check("R2 masked no irq", {31'b0, irq}, 32'h0);
        rd(3, 0, v); check("R7 masked summary", v, 32'h0);
        wr(0, 0, 32'hFFFF_FFFF);
        rd(0, 5, v); check("R4 clear all", v, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(1, 2, 32'h0000_00F0);
        rd(1, 4, v); check("R3 mask clr", v, 32'hFFFF_FF0F);
        wr(1, 1, 32'h0000_0030);
        rd(1, 4, v); check("R3 mask set", v, 32'hFFFF_FF3F);
        wr(1, 2, 32'h0);
        rd(1, 4, v); check("R3 zero write", v, 32'hFFFF_FF3F);
        rd(1, 1, v); check("R10 wo offset", v, 32'h0);
        wr(1, 1, 32'hFFFF_FFFF);
    endtask

    task automatic t_clear_modes();
        logic [31:0] v;
        pulse(2, 32'h0000_00A5);
        wr(2, 0, 32'h0000_0005);
        rd(2, 5, v); check("R4 w1c", v, 32'h0000_00A0);
        wr(2, 0, 32'h0);
        rd(2, 5, v); check("R4 zero write", v, 32'h0000_00A0);
        wr(2, 3, 32'h0000_000F);
        rd(2, 3, v); check("R10 mode readback", v, 32'h0000_000F);
        pulse(2, 32'h0000_000F);
        wr(2, 0, 32'h0000_00FF);
        rd(2, 5, v); check("R4 mode1 immune", v, 32'h0000_000F);
        rd(2, 0, v); check("R5 cor returns", v, 32'h0000_000F);
        rd(2, 5, v); check("R5 cor cleared", v, 32'h0);
        pulse(2, 32'h0000_00F3);
        rd(2, 0, v); check("R5 cor mixed", v, 32'h0000_00F3);
        rd(2, 5, v); check("R5 mode0 kept", v, 32'h0000_00F0);
        wr(2, 0, 32'h0000_00F0);
        wr(2, 3, 32'h0);
        rd(2, 5, v); check("R4 cleanup", v, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        pulse(0, 32'h4);
        @(negedge clk);
        wr_en = 1'b1; addr = adr(0, 0); wdata = 32'h4; tx_evt = 32'h4;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; tx_evt = '0;
        rd(0, 5, v); check("R6 w1c vs event", v, 32'h4);
        wr(0, 0, 32'h4);
        wr(0, 3, 32'hFFFF_FFFF);
        pulse(0, 32'h1);
        @(negedge clk);
        rd_en = 1'b1; addr = adr(0, 0); tx_evt = 32'h5;
        @(negedge clk);
        rd_en = 1'b0; tx_evt = '0;
        check("R6 cor returned", rdata, 32'h1);
        rd(0, 5, v); check("R6 cor vs event", v, 32'h5);
        rd(0, 0, v); check("R5 second read", v, 32'h5);
        rd(0, 5, v); check("R5 emptied", v, 32'h0);
        wr(0, 3, 32'h0);
    endtask

    task automatic t_summary_irq();
        logic [31:0] v;
        wr(3, 1, 32'hFFFF_FFF8);
        wr(1, 2, 32'h2);
        pulse(1, 32'h2);
        check("R8 not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R8 rise", {31'b0, irq}, 32'h1);
        rd(3, 0, v); check("R7 summary rx", v, 32'h2);
        wr(1, 0, 32'h2);
        check("R8 still high", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R8 fall", {31'b0, irq}, 32'h0);
        rd(3, 0, v); check("R7 sticky", v, 32'h2);
        rd(3, 0, v); check("R7 cleared", v, 32'h0);
    endtask

    task automatic t_enable_select();
        logic [31:0] v;
        wr(3, 1, 32'hFFFF_FFFB);
        pulse(1, 32'h2);
        repeat (2) @(negedge clk);
        check("R9 rx disabled", {31'b0, irq}, 32'h0);
        wr(2, 2, 32'h1);
        pulse(2, 32'h1);
        repeat (2) @(negedge clk);
        check("R9 misc enabled", {31'b0, irq}, 32'h1);
        rd(3, 0, v); check("R7 enable ignored", v, 32'h6);
        wr(3, 1, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        check("R9 all off", {31'b0, irq}, 32'h0);
        rd(3, 1, v); check("R10 enable readback", v, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch_masked();
        t_mask();
        t_clear_modes();
        t_set_wins();
        t_summary_irq();
        t_enable_select();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule